// File: doc/BRIEF.md
# Legacy and Message Interrupt Aggregator

This block gathers interrupt events from a link controller and turns them into one level interrupt for the host. Four legacy interrupt lines report their transitions as single-cycle pulses. Each assert pulse and each deassert pulse sets its own bit in a primary status register. A message-interrupt port delivers a vector index from 0 to 31 together with a 16-bit payload. Each such message sets the matching bit of a 32-bit vector status register and loads the payload into a holding register.

Software reads and clears the status registers by writing 1 to the bits it wants cleared. Each status register has a mask register beside it, where a 1 blocks that bit. Bit 24 of the primary status is a summary flag. It reports that at least one unmasked vector is pending, and it cannot be cleared while such a vector remains. The host interrupt output is high whenever any primary status bit is set and not masked.

Register map, as word indices on the 3-bit address: 0 primary status (bits [26:0]), 1 primary mask, 2 vector status, 3 vector mask, 4 payload. Any other index reads as zero. The read port is combinational.

Top module: `irq_aggregator`

## Requirements
- R1: Out of reset, primary status, vector status and payload read 0. The primary mask reads 0x07FFFFFF, the vector mask reads 0xFFFFFFFF, and `irq` is low.
- R2: An assert pulse on legacy line n (n = 0..3) sets primary status bit 16+n, and a deassert pulse sets bit 20+n. The bit reads as set from the clock edge that samples the pulse.
- R3: A write to primary status (index 0) clears exactly the bits written as 1. Bits written as 0 keep their value.
- R4: When an event and a write-1-to-clear hit the same status bit in the same cycle, the bit stays set. This holds for both primary and vector status.
- R5: A message with vector v sets vector status bit v. Writing 1 to that bit at index 2 clears it.
- R6: Every message, masked or not, loads its full 16-bit payload into the payload register (index 4). The register keeps the most recent payload, and its low 8 bits carry the message data.
- R7: Primary status bit 24 sets at the edge where a message arrives for an unmasked vector. It also sets one edge after any vector status bit becomes unmasked. A message to a masked vector leaves bit 24 clear.
- R8: Writing 1 to primary status bit 24 has no effect while any unmasked vector status bit is set. Once none remain, the same write clears it.
- R9: `irq` is high exactly when some primary status bit is 1 while its primary mask bit is 0.
- R10: The mask registers read back the value last written (the primary mask keeps bits [26:0] only). Writes to other indices do not change them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register write word index |
| wr_data | input | 32 | Register write data |
| rd_addr | input | 3 | Register read word index |
| rd_data | output | 32 | Register read data (combinational) |
| intx_assert | input | 4 | Legacy line assert event pulses |
| intx_deassert | input | 4 | Legacy line deassert event pulses |
| msg_valid | input | 1 | Message interrupt received this cycle |
| msg_vector | input | 5 | Vector index of the message |
| msg_payload | input | 16 | Payload of the message |
| irq | output | 1 | Level summary interrupt to the host |

## Verification
The bench uses the default parameters: four legacy lines, 32 vectors, a 16-bit payload and a 32-bit data word. With these values it can drive vector 31, so the top vector bit and the all-ones vector mask can be checked directly. Directed sequences cover clear-versus-set collisions and the pending flag staying set while a vector is still pending. A long random phase then mixes writes to every index, including the unmapped ones, with concurrent line pulses and messages.

// File: rtl/irq_agg_pkg.sv
// Shared register indices and primary status bit positions for the
// interrupt aggregator. Bit positions are fixed because software decodes them.
package irq_agg_pkg;
    typedef enum logic [2:0] {
        IDX_PSTAT = 3'd0,
        IDX_PMASK = 3'd1,
        IDX_VSTAT = 3'd2,
        IDX_VMASK = 3'd3,
        IDX_PAYLD = 3'd4
    } reg_idx_e;

    localparam int PRIM_W       = 27;
    localparam int ASSERT_LSB   = 16;
    localparam int DEASSERT_LSB = 20;
    localparam int PEND_BIT     = 24;
endpackage

// File: rtl/irq_w1c_bank.sv
// Bank of status bits: set by events, cleared by write-one-to-clear.
// Assumes set_i and clr_i are single-cycle; a set wins over a clear.
module irq_w1c_bank #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] set_i,
    input  logic [W-1:0] clr_i,
    output logic [W-1:0] q_o
);
    // Update: drop cleared bits, then apply new events on top.
    always_ff @(posedge clk) begin
        if (!rst_n) q_o <= '0;
        else        q_o <= (q_o & ~clr_i) | set_i;
    end
endmodule

// File: rtl/irq_rw_reg.sv
// Plain software-writable register with a parameterised reset value.
module irq_rw_reg #(
    parameter int         W       = 8,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         we_i,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);
    // Load on write strobe, hold otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n)    q_o <= RST_VAL;
        else if (we_i) q_o <= d_i;
    end
endmodule

// File: rtl/irq_vec_unit.sv
// Message interrupt unit: per-vector status with mask, payload holding
// register, and the request that feeds the primary pending flag.
// Assumes at most one message per cycle.
module irq_vec_unit #(
    parameter int NUM_VEC = 32,
    parameter int PAY_W   = 16,
    localparam int VIDX_W = $clog2(NUM_VEC)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               msg_valid_i,
    input  logic [VIDX_W-1:0]  msg_vector_i,
    input  logic [PAY_W-1:0]   msg_payload_i,
    input  logic [NUM_VEC-1:0] stat_clr_i,
    input  logic               mask_we_i,
    input  logic [NUM_VEC-1:0] mask_d_i,
    output logic [NUM_VEC-1:0] vstat_o,
    output logic [NUM_VEC-1:0] vmask_o,
    output logic [PAY_W-1:0]   payload_o,
    output logic               pend_req_o
);
    logic [NUM_VEC-1:0] hit;

    // One decoder slice per vector.
    for (genvar v = 0; v < NUM_VEC; v++) begin : g_dec
        assign hit[v] = msg_valid_i && (msg_vector_i == VIDX_W'(v));
    end

    irq_w1c_bank #(.W(NUM_VEC)) u_vstat (
        .clk   (clk),
        .rst_n (rst_n),
        .set_i (hit),
        .clr_i (stat_clr_i),
        .q_o   (vstat_o)
    );

    irq_rw_reg #(.W(NUM_VEC), .RST_VAL({NUM_VEC{1'b1}})) u_vmask (
        .clk   (clk),
        .rst_n (rst_n),
        .we_i  (mask_we_i),
        .d_i   (mask_d_i),
        .q_o   (vmask_o)
    );

    // Capture the payload of every message received.
    always_ff @(posedge clk) begin
        if (!rst_n)           payload_o <= '0;
        else if (msg_valid_i) payload_o <= msg_payload_i;
    end

    // Request pending whenever an unmasked vector is set or arriving.
    always_comb begin
        pend_req_o = |((vstat_o | hit) & ~vmask_o);
    end
endmodule

// File: rtl/irq_aggregator.sv
// Interrupt aggregator top: primary status/mask, message unit, register
// read mux and level summary interrupt. Assumes NUM_LINES fits the 4-bit
// slots at ASSERT_LSB/DEASSERT_LSB and DATA_W covers PRIM_W and NUM_VEC.
module irq_aggregator
    import irq_agg_pkg::*;
#(
    parameter int NUM_LINES = 4,
    parameter int NUM_VEC   = 32,
    parameter int PAY_W     = 16,
    parameter int DATA_W    = 32,
    parameter int ADDR_W    = 3,
    localparam int VIDX_W   = $clog2(NUM_VEC)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en,
    input  logic [ADDR_W-1:0]    wr_addr,
    input  logic [DATA_W-1:0]    wr_data,
    input  logic [ADDR_W-1:0]    rd_addr,
    output logic [DATA_W-1:0]    rd_data,
    input  logic [NUM_LINES-1:0] intx_assert,
    input  logic [NUM_LINES-1:0] intx_deassert,
    input  logic                 msg_valid,
    input  logic [VIDX_W-1:0]    msg_vector,
    input  logic [PAY_W-1:0]     msg_payload,
    output logic                 irq
);
    logic                wr_pstat, wr_pmask, wr_vstat, wr_vmask;
    logic [PRIM_W-1:0]   prim_set, prim_clr;
    logic [PRIM_W-1:0]   prim_status_q, prim_mask_q;
    logic [NUM_VEC-1:0]  vstat_q, vmask_q, vclr;
    logic [PAY_W-1:0]    payload_q;
    logic                pend_req;

    // Write decode per register index.
    always_comb begin
        wr_pstat = wr_en && (wr_addr == ADDR_W'(IDX_PSTAT));
        wr_pmask = wr_en && (wr_addr == ADDR_W'(IDX_PMASK));
        wr_vstat = wr_en && (wr_addr == ADDR_W'(IDX_VSTAT));
        wr_vmask = wr_en && (wr_addr == ADDR_W'(IDX_VMASK));
    end

    // Gather primary status events into their fixed bit positions.
    always_comb begin
        prim_set = '0;
        prim_set[ASSERT_LSB   +: NUM_LINES] = intx_assert;
        prim_set[DEASSERT_LSB +: NUM_LINES] = intx_deassert;
        prim_set[PEND_BIT]                  = pend_req;
        prim_clr = wr_pstat ? wr_data[PRIM_W-1:0] : '0;
        vclr     = wr_vstat ? wr_data[NUM_VEC-1:0] : '0;
    end

    irq_w1c_bank #(.W(PRIM_W)) u_pstat (
        .clk   (clk),
        .rst_n (rst_n),
        .set_i (prim_set),
        .clr_i (prim_clr),
        .q_o   (prim_status_q)
    );

    irq_rw_reg #(.W(PRIM_W), .RST_VAL({PRIM_W{1'b1}})) u_pmask (
        .clk   (clk),
        .rst_n (rst_n),
        .we_i  (wr_pmask),
        .d_i   (wr_data[PRIM_W-1:0]),
        .q_o   (prim_mask_q)
    );

    irq_vec_unit #(.NUM_VEC(NUM_VEC), .PAY_W(PAY_W)) u_vec (
        .clk           (clk),
        .rst_n         (rst_n),
        .msg_valid_i   (msg_valid),
        .msg_vector_i  (msg_vector),
        .msg_payload_i (msg_payload),
        .stat_clr_i    (vclr),
        .mask_we_i     (wr_vmask),
        .mask_d_i      (wr_data[NUM_VEC-1:0]),
        .vstat_o       (vstat_q),
        .vmask_o       (vmask_q),
        .payload_o     (payload_q),
        .pend_req_o    (pend_req)
    );

    // Summary interrupt from unmasked primary status.
    always_comb begin
        irq = |(prim_status_q & ~prim_mask_q);
    end

    // Register read mux; unmapped indices read zero.
    always_comb begin
        case (rd_addr)
            ADDR_W'(IDX_PSTAT): rd_data = DATA_W'(prim_status_q);
            ADDR_W'(IDX_PMASK): rd_data = DATA_W'(prim_mask_q);
            ADDR_W'(IDX_VSTAT): rd_data = DATA_W'(vstat_q);
            ADDR_W'(IDX_VMASK): rd_data = DATA_W'(vmask_q);
            ADDR_W'(IDX_PAYLD): rd_data = DATA_W'(payload_q);
            default:            rd_data = '0;
        endcase
    end
endmodule

// File: rtl/irq_agg_checker.sv
// Property checker for the interrupt aggregator, bound to every instance.
module irq_agg_checker
    import irq_agg_pkg::*;
#(
    parameter int NUM_LINES = 4,
    parameter int NUM_VEC   = 32,
    parameter int PAY_W     = 16,
    localparam int VIDX_W   = $clog2(NUM_VEC)
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic [NUM_LINES-1:0] intx_assert,
    input logic [NUM_LINES-1:0] intx_deassert,
    input logic                 msg_valid,
    input logic [VIDX_W-1:0]    msg_vector,
    input logic [PAY_W-1:0]     msg_payload,
    input logic [PRIM_W-1:0]    prim_status_q,
    input logic [NUM_VEC-1:0]   vstat_q,
    input logic [NUM_VEC-1:0]   vmask_q,
    input logic [PAY_W-1:0]     payload_q,
    input logic                 irq
);
    // R1: first cycle after reset release shows cleared state
    assert_reset_clear_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (prim_status_q == '0 && vstat_q == '0 && !irq));

    // R2: assert and deassert pulses land in their status slots
    assert_line_event_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (intx_assert != '0 || intx_deassert != '0) |=>
        (((prim_status_q[ASSERT_LSB +: NUM_LINES] & $past(intx_assert)) == $past(intx_assert)) &&
         ((prim_status_q[DEASSERT_LSB +: NUM_LINES] & $past(intx_deassert)) == $past(intx_deassert))));

    // R5: message sets its vector bit
    assert_vec_set_R5: assert property (@(posedge clk) disable iff (!rst_n)
        msg_valid |=> vstat_q[$past(msg_vector)]);

    // R6: payload register tracks the latest message
    assert_payload_R6: assert property (@(posedge clk) disable iff (!rst_n)
        msg_valid |=> (payload_q == $past(msg_payload)));

    // R7: unmasked pending vector raises the primary pending flag
    assert_pend_set_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ((vstat_q & ~vmask_q) != '0) |=> prim_status_q[PEND_BIT]);

    // R8: pending flag only falls when no unmasked vector was pending
    assert_pend_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(prim_status_q[PEND_BIT]) |->
        $past(((vstat_q & ~vmask_q) == '0) && !(msg_valid && !vmask_q[msg_vector])));
endmodule

bind irq_aggregator irq_agg_checker #(
    .NUM_LINES (NUM_LINES),
    .NUM_VEC   (NUM_VEC),
    .PAY_W     (PAY_W)
) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .intx_assert   (intx_assert),
    .intx_deassert (intx_deassert),
    .msg_valid     (msg_valid),
    .msg_vector    (msg_vector),
    .msg_payload   (msg_payload),
    .prim_status_q (prim_status_q),
    .vstat_q       (vstat_q),
    .vmask_q       (vmask_q),
    .payload_q     (payload_q),
    .irq           (irq)
);

// File: tb/tb_irq_aggregator.sv
`timescale 1ns/1ps
module tb_irq_aggregator;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic [2:0]  rd_addr = '0;
    logic [31:0] rd_data;
    logic [3:0]  intx_assert = '0;
    logic [3:0]  intx_deassert = '0;
    logic        msg_valid = 1'b0;
    logic [4:0]  msg_vector = '0;
    logic [15:0] msg_payload = '0;
    logic        irq;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    // reference model state
    logic [26:0] m_prim;
    logic [26:0] m_pmask;
    logic [31:0] m_vst;
    logic [31:0] m_vmk;
    logic [15:0] m_pay;

    always #2.5 clk = ~clk;

    irq_aggregator dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
        .intx_assert(intx_assert), .intx_deassert(intx_deassert),
        .msg_valid(msg_valid), .msg_vector(msg_vector),
        .msg_payload(msg_payload), .irq(irq)
    );

    task automatic check_eq(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=0x%08h expected=0x%08h at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic logic [31:0] model_read(input logic [2:0] a);
        case (a)
            3'd0: return {5'd0, m_prim};
            3'd1: return {5'd0, m_pmask};
            3'd2: return m_vst;
            3'd3: return m_vmk;
            3'd4: return {16'd0, m_pay};
            default: return 32'd0;
        endcase
    endfunction

    function automatic string tag_of(input logic [2:0] a);
        case (a)
            3'd0: return "R2";
            3'd2: return "R5";
            3'd4: return "R6";
            default: return "R10";
        endcase
    endfunction

    // behavioural model, updated at each edge, compared 1 ns later
    always @(posedge clk) begin
        bit pend;
        if (!rst_n) begin
            m_prim = '0; m_pmask = '1; m_vst = '0; m_vmk = '1; m_pay = '0;
        end else begin
            pend = 1'b0;
            for (int v = 0; v < 32; v++) if (m_vst[v] && !m_vmk[v]) pend = 1'b1;
            if (msg_valid && !m_vmk[msg_vector]) pend = 1'b1;
            if (wr_en && wr_addr == 3'd0) m_prim = m_prim & ~wr_data[26:0];
            for (int n = 0; n < 4; n++) begin
                if (intx_assert[n])   m_prim[16+n] = 1'b1;
                if (intx_deassert[n]) m_prim[20+n] = 1'b1;
            end
            if (pend) m_prim[24] = 1'b1;
            if (wr_en && wr_addr == 3'd2) m_vst = m_vst & ~wr_data;
            if (msg_valid) begin
                m_vst[msg_vector] = 1'b1;
                m_pay = msg_payload;
            end
            if (wr_en && wr_addr == 3'd1) m_pmask = wr_data[26:0];
            if (wr_en && wr_addr == 3'd3) m_vmk = wr_data;
        end
        #1;
        if (rst_n && !done) begin
            check_eq("R9 irq", {31'd0, irq}, {31'd0, |(m_prim & ~m_pmask)});
            check_eq(tag_of(rd_addr), rd_data, model_read(rd_addr));
        end
    end

    task automatic drive(input logic we, input logic [2:0] a, input logic [31:0] d,
                         input logic [3:0] ia, input logic [3:0] id,
                         input logic mv, input logic [4:0] vec, input logic [15:0] pay);
        @(negedge clk);
        wr_en = we; wr_addr = a; wr_data = d;
        intx_assert = ia; intx_deassert = id;
        msg_valid = mv; msg_vector = vec; msg_payload = pay;
        @(negedge clk);
        wr_en = 0; intx_assert = 0; intx_deassert = 0; msg_valid = 0;
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        drive(1'b1, a, d, 4'd0, 4'd0, 1'b0, 5'd0, 16'd0);
    endtask

    task automatic expect_reg(input string tag, input logic [2:0] a, input logic [31:0] exp);
        @(negedge clk);
        rd_addr = a;
        #0.5;
        check_eq(tag, rd_data, exp);
    endtask

    task automatic expect_irq(input string tag, input logic exp);
        check_eq(tag, {31'd0, irq}, {31'd0, exp});
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        expect_reg("R1 pstat", 3'd0, 32'h0);
        expect_reg("R1 pmask", 3'd1, 32'h07FF_FFFF);
        expect_reg("R1 vstat", 3'd2, 32'h0);
        expect_reg("R1 vmask", 3'd3, 32'hFFFF_FFFF);
        expect_reg("R1 payload", 3'd4, 32'h0);
        expect_irq("R1 irq", 1'b0);
        // R2 assert on line 2, deassert on line 1
        drive(1'b0, 3'd0, 0, 4'b0100, 4'b0010, 1'b0, 5'd0, 16'd0);
        expect_reg("R2 pstat", 3'd0, 32'h0024_0000);
        expect_irq("R9 masked", 1'b0);
        // R10 / R9 masks
        wr(3'd1, 32'h0);
        expect_reg("R10 pmask", 3'd1, 32'h0);
        expect_irq("R9 unmasked", 1'b1);
        wr(3'd1, 32'hFFFF_FFFF);
        expect_reg("R10 pmask width", 3'd1, 32'h07FF_FFFF);
        wr(3'd1, 32'h0024_0000);
        expect_irq("R9 selective mask", 1'b0);
        wr(3'd1, 32'h0);
        // R3 selective clear
        wr(3'd0, 32'h0004_0000);
        expect_reg("R3 pstat", 3'd0, 32'h0020_0000);
        expect_irq("R9 remaining", 1'b1);
        // R4 set wins over clear
        drive(1'b1, 3'd0, 32'h0028_0000, 4'b1000, 4'd0, 1'b0, 5'd0, 16'd0);
        expect_reg("R4 pstat", 3'd0, 32'h0008_0000);
        wr(3'd0, 32'h07FF_FFFF);
        expect_reg("R3 clear all", 3'd0, 32'h0);
        expect_irq("R9 idle", 1'b0);
        // R5 / R6 / R7 masked message
        drive(1'b0, 3'd0, 0, 4'd0, 4'd0, 1'b1, 5'd5, 16'h12AB);
        expect_reg("R5 vstat", 3'd2, 32'h0000_0020);
        expect_reg("R6 payload", 3'd4, 32'h0000_12AB);
        expect_reg("R7 masked no pend", 3'd0, 32'h0);
        // R7 unmasking raises pending
        wr(3'd3, 32'hFFFF_FFDF);
        expect_reg("R7 pend", 3'd0, 32'h0100_0000);
        expect_irq("R9 pend", 1'b1);
        // R8 clear blocked while vector pending
        wr(3'd0, 32'h0100_0000);
        expect_reg("R8 blocked", 3'd0, 32'h0100_0000);
        wr(3'd2, 32'h0000_0020);
        expect_reg("R5 vclear", 3'd2, 32'h0);
        wr(3'd0, 32'h0100_0000);
        expect_reg("R8 cleared", 3'd0, 32'h0);
        // R4 vector collision on top index
        drive(1'b1, 3'd2, 32'h8000_0000, 4'd0, 4'd0, 1'b1, 5'd31, 16'hBEEF);
        expect_reg("R4 vstat", 3'd2, 32'h8000_0000);
        expect_reg("R6 payload", 3'd4, 32'h0000_BEEF);
        expect_reg("R7 masked top", 3'd0, 32'h0);
        drive(1'b0, 3'd0, 0, 4'd0, 4'd0, 1'b1, 5'd0, 16'h0001);
        expect_reg("R5 two vectors", 3'd2, 32'h8000_0001);
        expect_reg("R6 latest", 3'd4, 32'h0000_0001);
        expect_reg("R10 vmask", 3'd3, 32'hFFFF_FFDF);
        // random phase, monitor compares every clock
        for (int i = 0; i < 3000; i++) begin
            @(negedge clk);
            wr_en = ($urandom_range(0, 3) == 0);
            wr_addr = 3'($urandom_range(0, 7));
            wr_data = $urandom();
            intx_assert = ($urandom_range(0, 7) == 0) ? 4'($urandom()) : 4'd0;
            intx_deassert = ($urandom_range(0, 7) == 0) ? 4'($urandom()) : 4'd0;
            msg_valid = ($urandom_range(0, 3) == 0);
            msg_vector = 5'($urandom());
            msg_payload = 16'($urandom());
            rd_addr = 3'(i % 8);
        end
        @(negedge clk);
        wr_en = 0; intx_assert = 0; intx_deassert = 0; msg_valid = 0;
        repeat (2) @(negedge clk);
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule